// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Register

This block gathers interrupt events of a ten-channel DMA controller into one 32-bit register that software reads and writes. Each channel raises a one-cycle completion pulse. Three controller-wide events, stall, memory-FIFO-empty and bus error, also raise pulses. Each pulse sets a sticky status bit that holds until software clears it. An enable field in the same register word decides which status bits can raise the single interrupt line to the CPU.

Software reads the word through a plain read port. A write has two effects at once. A one written at a status position clears that status bit. A one written at an enable position inverts that enable. A zero at either kind of position leaves the bit alone. Because of this, software can acknowledge events and adjust enables without a read-modify-write race. Register accesses take a single cycle. The event inputs and the interrupt line are plain level and pulse pins, with no handshake.

Top module: `dmairq_ctl`

## Requirements
- R1: After reset every status bit and every enable bit reads zero, and `irq` is low.
- R2: A pulse on `chan_done[n]` sets status bit n (bits 9:0). The bit stays set in every later cycle until a clear write removes it.
- R3: A pulse on `stall_evt` sets bit 13, a pulse on `fifo_empty_evt` sets bit 14, and a pulse on `bus_err_evt` sets bit 15. Each of these bits is sticky in the same way as in R2.
- R4: A write with a one at status position 0-9, 13, 14 or 15 clears that bit. Status bits written with zero keep their value.
- R5: If an event and a clear of the same status bit occur in the same cycle, the bit is set after that cycle.
- R6: A write with a one at enable position 16+n (channel n), 29 (stall) or 30 (FIFO-empty) inverts that enable bit. Enable bits written with zero keep their value.
- R7: `irq` is high exactly when one of these holds: a channel status bit is set together with its enable, bit 13 is set together with bit 29, bit 30 is set together with bit 14, or bit 15 is set.
- R8: Status bit 15 (bus error) drives `irq` high whatever the enable bits hold.
- R9: Bits 10-12, 26-28 and 31 always read zero, and writing ones to them changes nothing.
- R10: Status and enable bits take their new value on the clock edge that samples the event or write. `reg_rdata` and `irq` show that value right after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe, one access per cycle |
| reg_wdata | input | 32 | Write data: ones clear status bits and invert enable bits |
| reg_rdata | output | 32 | Current status and enable word |
| chan_done | input | 10 | Per-channel completion pulses |
| stall_evt | input | 1 | Stall event pulse |
| fifo_empty_evt | input | 1 | Memory-FIFO-empty event pulse |
| bus_err_evt | input | 1 | Bus error event pulse |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench targets several corner cases, and each has a distinct failure mode:
- **Event and clear in the same cycle.** A design with the wrong priority would lose that event.
- **Enable written with one twice in a row.** A design that loads enables instead of toggling them would leave the enable set after the second write.
- **Bus error with every enable off.** A design that gates the bus-error bit would miss the interrupt.
- **Ones written to the unused positions.** A design that stored them would read back stray bits.

Random traffic mixes sparse events with random writes. It catches a bit that is not sticky, a clear that spreads to a neighbouring bit, or an interrupt term paired with the wrong enable.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int unsigned REG_W          = 32;
  localparam int unsigned CH_STAT_LSB    = 0;
  localparam int unsigned CH_EN_LSB      = 16;
  localparam int unsigned STALL_STAT_BIT = 13;
  localparam int unsigned FIFO_STAT_BIT  = 14;
  localparam int unsigned BERR_STAT_BIT  = 15;
  localparam int unsigned STALL_EN_BIT   = 29;
  localparam int unsigned FIFO_EN_BIT    = 30;
  localparam int unsigned GLOBAL_SRCS    = 3;  // stall, fifo empty, bus error
  localparam int unsigned GLOBAL_ENS     = 2;  // stall, fifo empty
endpackage

// File: rtl/dmairq_sticky.sv
module dmairq_sticky #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;   // set has priority over clear
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/dmairq_toggle.sv
module dmairq_toggle #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tgl_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        q_o[i] <= 1'b0;
      else if (tgl_i[i]) q_o[i] <= ~q_o[i];
    end
  end
endmodule

// File: rtl/dmairq_combine.sv
module dmairq_combine #(
  parameter int unsigned NCH = 10
) (
  input  logic [NCH-1:0] chan_stat,
  input  logic [NCH-1:0] chan_en,
  input  logic           stall_stat,
  input  logic           stall_en,
  input  logic           fifo_stat,
  input  logic           fifo_en,
  input  logic           berr_stat,
  output logic           irq_o
);
  logic chan_any;
  assign chan_any = |(chan_stat & chan_en);
  assign irq_o    = chan_any | (stall_stat & stall_en) | (fifo_stat & fifo_en) | berr_stat;
endmodule

// File: rtl/dmairq_ctl.sv
module dmairq_ctl
  import dmairq_pkg::*;
#(
  parameter int unsigned NUM_CH = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NUM_CH-1:0] chan_done,
  input  logic              stall_evt,
  input  logic              fifo_empty_evt,
  input  logic              bus_err_evt,
  output logic              irq
);
  localparam int unsigned SW = NUM_CH + GLOBAL_SRCS;
  localparam int unsigned EW = NUM_CH + GLOBAL_ENS;

  // status vector layout: {berr, fifo, stall, chan[NUM_CH-1:0]}
  logic [SW-1:0] stat_set, stat_clr, stat_q;
  // enable vector layout: {fifo_en, stall_en, chan_en[NUM_CH-1:0]}
  logic [EW-1:0] en_tgl, en_q;

  assign stat_set = {bus_err_evt, fifo_empty_evt, stall_evt, chan_done};
  assign stat_clr = reg_wr_en ? {reg_wdata[BERR_STAT_BIT], reg_wdata[FIFO_STAT_BIT],
                                 reg_wdata[STALL_STAT_BIT], reg_wdata[CH_STAT_LSB +: NUM_CH]}
                              : '0;
  assign en_tgl   = reg_wr_en ? {reg_wdata[FIFO_EN_BIT], reg_wdata[STALL_EN_BIT],
                                 reg_wdata[CH_EN_LSB +: NUM_CH]}
                              : '0;

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^reg_wdata;

  dmairq_sticky #(.W(SW)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_i(stat_set), .clr_i(stat_clr), .q_o(stat_q)
  );

  dmairq_toggle #(.W(EW)) u_en (
    .clk(clk), .rst_n(rst_n), .tgl_i(en_tgl), .q_o(en_q)
  );

  dmairq_combine #(.NCH(NUM_CH)) u_comb (
    .chan_stat (stat_q[NUM_CH-1:0]),
    .chan_en   (en_q[NUM_CH-1:0]),
    .stall_stat(stat_q[NUM_CH]),
    .stall_en  (en_q[NUM_CH]),
    .fifo_stat (stat_q[NUM_CH+1]),
    .fifo_en   (en_q[NUM_CH+1]),
    .berr_stat (stat_q[NUM_CH+2]),
    .irq_o     (irq)
  );

  always_comb begin
    reg_rdata                          = '0;
    reg_rdata[CH_STAT_LSB +: NUM_CH]   = stat_q[NUM_CH-1:0];
    reg_rdata[STALL_STAT_BIT]          = stat_q[NUM_CH];
    reg_rdata[FIFO_STAT_BIT]           = stat_q[NUM_CH+1];
    reg_rdata[BERR_STAT_BIT]           = stat_q[NUM_CH+2];
    reg_rdata[CH_EN_LSB +: NUM_CH]     = en_q[NUM_CH-1:0];
    reg_rdata[STALL_EN_BIT]            = en_q[NUM_CH];
    reg_rdata[FIFO_EN_BIT]             = en_q[NUM_CH+1];
  end
endmodule

// File: rtl/dmairq_ctl_chk.sv
module dmairq_ctl_chk #(
  parameter int unsigned NUM_CH = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [NUM_CH-1:0] chan_done,
  input logic              stall_evt,
  input logic              fifo_empty_evt,
  input logic              bus_err_evt,
  input logic              irq
);
  localparam logic [31:0] CH_FIELD = (32'd1 << NUM_CH) - 32'd1;
  localparam logic [31:0] STAT_M   = CH_FIELD | 32'h0000_E000;
  localparam logic [31:0] EN_M     = (CH_FIELD << 16) | 32'h6000_0000;

  logic [31:0] ev_word, wr_word, keep_set, clr_eff, en_next, gated;
  assign ev_word  = (32'(chan_done) & CH_FIELD) | (32'(stall_evt) << 13)
                  | (32'(fifo_empty_evt) << 14) | (32'(bus_err_evt) << 15);
  assign wr_word  = reg_wr_en ? reg_wdata : 32'd0;
  assign keep_set = reg_rdata & STAT_M & ~wr_word;
  assign clr_eff  = wr_word & STAT_M & ~ev_word;
  assign en_next  = (reg_rdata & EN_M) ^ (wr_word & EN_M);
  assign gated    = reg_rdata & (reg_rdata >> 16) & CH_FIELD;

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((reg_rdata & $past(keep_set)) == $past(keep_set)));

  assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((reg_rdata & $past(ev_word)) == $past(ev_word)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((reg_rdata & $past(clr_eff)) == 32'd0));

  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((reg_rdata & EN_M) == $past(en_next)));

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~(STAT_M | EN_M)) == 32'd0);

  assert_buserr_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[15] |-> irq);

  assert_quiet_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gated == 32'd0 && !(reg_rdata[13] && reg_rdata[29]) &&
     !(reg_rdata[14] && reg_rdata[30]) && !reg_rdata[15]) |-> !irq);
endmodule

bind dmairq_ctl dmairq_ctl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .chan_done(chan_done), .stall_evt(stall_evt),
  .fifo_empty_evt(fifo_empty_evt), .bus_err_evt(bus_err_evt), .irq(irq)
);

// File: tb/dmairq_ctl_test.sv
`timescale 1ns/1ps
module dmairq_ctl_test;
  localparam int NCH = 10;
  localparam logic [31:0] STAT_M = 32'h0000_E3FF;
  localparam logic [31:0] EN_M   = 32'h63FF_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] chan = '0;
  logic stall = 1'b0, fifo = 1'b0, berr = 1'b0;
  logic irq;

  int total = 0, bad = 0;
  logic [31:0] m_word = '0;   // bench model of the register word

  always #2 clk = ~clk;  // 250 MHz

  dmairq_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wdata(wdata), .reg_rdata(rdata),
    .chan_done(chan), .stall_evt(stall), .fifo_empty_evt(fifo), .bus_err_evt(berr), .irq(irq)
  );

  function automatic logic [31:0] next_word(logic [31:0] w, logic [31:0] ev, logic we, logic [31:0] d);
    logic [31:0] dd = we ? d : 32'd0;
    logic [31:0] st = ((w & STAT_M) & ~(dd & STAT_M)) | (ev & STAT_M);
    logic [31:0] en = (w & EN_M) ^ (dd & EN_M);
    return st | en;
  endfunction

  function automatic logic exp_irq(logic [31:0] w);
    return (|(w[9:0] & w[25:16])) | (w[13] & w[29]) | (w[14] & w[30]) | w[15];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, update model at the rising edge, check after it
  task automatic step(logic [31:0] ev, logic we, logic [31:0] d, string req);
    @(negedge clk);
    chan = ev[9:0]; stall = ev[13]; fifo = ev[14]; berr = ev[15];
    wr_en = we; wdata = d;
    @(posedge clk);
    m_word = next_word(m_word, ev, we, d);
    #1;
    check({req, " word"}, rdata, m_word);
    check({req, " irq"}, {31'd0, irq}, {31'd0, exp_irq(m_word)});
    @(negedge clk);
    chan = '0; stall = 0; fifo = 0; berr = 0; wr_en = 0; wdata = '0;
  endtask

  initial begin : watchdog
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 reset word", rdata, 32'd0);
    check("R1 reset irq", {31'd0, irq}, 32'd0);

    // R2/R10: channel 3 pulse, sticky, masked so no irq
    step(32'h0000_0008, 0, 0, "R2 R10 ch3 set");
    step(32'h0, 0, 0, "R2 ch3 sticky");
    // R6: enable ch3 by toggle -> irq (R7)
    step(32'h0, 1, 32'h0008_0000, "R6 R7 enable ch3");
    // R6: toggle again -> disabled
    step(32'h0, 1, 32'h0008_0000, "R6 toggle back");
    // R4: clear ch3 alone, other bits zero untouched
    step(32'h0000_0001, 0, 0, "R2 ch0 set");
    step(32'h0, 1, 32'h0000_0008, "R4 clear ch3 keep ch0");
    // R5: event and clear together on ch0
    step(32'h0000_0001, 1, 32'h0000_0001, "R5 event beats clear");
    // R3: globals
    step(32'h0000_6000, 0, 0, "R3 stall fifo set");
    step(32'h0, 1, 32'h2000_0000, "R7 stall enable");
    step(32'h0, 1, 32'h6000_2000, "R7 R4 clear stall swap enables");
    // R8: bus error with enables cleared
    step(32'h0, 1, 32'h4000_4001, "R4 clear rest");
    check("R8 quiet before", {31'd0, irq}, 32'd0);
    step(32'h0000_8000, 0, 0, "R3 R8 bus error irq");
    // R9: write unused bits
    step(32'h0, 1, 32'h9C00_1C00, "R9 unused ignored");
    step(32'h0, 1, 32'h0000_8000, "R4 clear berr");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ev = $urandom() & $urandom() & $urandom() & STAT_M;
      logic we = ($urandom() % 3) == 0;
      logic [31:0] d = $urandom();
      step(ev, we, d, "R2 R4 R6 R7 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule